// File: doc/BRIEF.md
# Pipeline Hazard Detection Unit

This block decides, every cycle, whether the front of a five-stage integer pipeline must pause or must discard work. Branch conditions and jump targets are computed in the decode stage. The unit looks at the instruction in decode, which source registers it reads and whether it is a branch or a jump. It also looks at the destinations of the instructions in execute and memory. From these it produces hold, bubble, flush and redirect controls.

A stall freezes the program counter and the fetch/decode register for one cycle and puts a bubble into the decode/execute register. A flush turns the single instruction that was fetched on the wrong path into a no-operation and steers the program counter to the computed target. Because control transfers resolve in decode, only the fetch slot is ever discarded, so the penalty is one cycle. All outputs are combinational from the current stage contents.

Top module: `hazard_ctl`

## Requirements
- R1: When the decode instruction is not a branch or a jump and the execute stage holds no load, all five outputs are 0.
- R2: A load in execute (write enable set) whose destination equals a decode source that is read raises pc_hold, ifid_hold and idex_bubble together. The comparison is made for rs1 and for rs2.
- R3: A non-load producer in execute or memory whose destination matches a source of an ordinary (non-branch, non-jump) decode instruction causes no stall.
- R4: A conditional branch or register-indirect jump in decode that reads a register which the execute instruction writes (write enable set) stalls, whether or not that instruction is a load.
- R5: A conditional branch or register-indirect jump in decode that reads a register which the memory-stage instruction writes (write enable set) stalls.
- R6: A match does not count when the source index is 0, when the matching source's read flag is 0, or when the producer's write enable is 0.
- R7: A taken conditional branch, a direct jump or a register-indirect jump raises ifid_flush and pc_redirect together. A branch that is not taken raises neither.
- R8: When a stall and a flush condition coincide, the stall outputs are 1 and ifid_flush and pc_redirect are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs1 | input | 5 | Decode first source register index |
| id_rs2 | input | 5 | Decode second source register index |
| id_rs1_rd | input | 1 | Decode instruction reads rs1 |
| id_rs2_rd | input | 1 | Decode instruction reads rs2 |
| id_is_br | input | 1 | Decode instruction is a conditional branch |
| id_is_jalr | input | 1 | Decode instruction is a register-indirect jump |
| id_is_jal | input | 1 | Decode instruction is a direct jump |
| id_br_taken | input | 1 | Branch condition computed in decode is true |
| ex_rd | input | 5 | Execute-stage destination index |
| ex_wen | input | 1 | Execute-stage register write enable |
| ex_load | input | 1 | Execute-stage instruction is a load |
| mem_rd | input | 5 | Memory-stage destination index |
| mem_wen | input | 1 | Memory-stage register write enable |
| pc_hold | output | 1 | Keep the program counter unchanged |
| ifid_hold | output | 1 | Keep the fetch/decode register unchanged |
| idex_bubble | output | 1 | Load a no-operation into decode/execute |
| ifid_flush | output | 1 | Replace the fetch/decode instruction with a no-operation |
| pc_redirect | output | 1 | Take the decode-computed target as next PC |

## Verification
The bench targets the split between consumers that need a stall and consumers that forwarding can serve. If an ALU consumer stalled behind a plain ALU producer, throughput would drop silently. If a branch did not stall behind that same producer, it would compare stale operands. It also covers register x0, read flags that are cleared, and write enables that are low; a design that ignored any of these would stall without need. The stall-versus-flush collision is checked as well, because a design that let the flush through would redirect to a target computed from stale data.

// File: rtl/hazard_ctl.sv
module hazard_ctl #(
  parameter int REG_IDX_W = 5
) (
  input  logic [REG_IDX_W-1:0] id_rs1,
  input  logic [REG_IDX_W-1:0] id_rs2,
  input  logic                 id_rs1_rd,
  input  logic                 id_rs2_rd,
  input  logic                 id_is_br,
  input  logic                 id_is_jalr,
  input  logic                 id_is_jal,
  input  logic                 id_br_taken,
  input  logic [REG_IDX_W-1:0] ex_rd,
  input  logic                 ex_wen,
  input  logic                 ex_load,
  input  logic [REG_IDX_W-1:0] mem_rd,
  input  logic                 mem_wen,
  output logic                 pc_hold,
  output logic                 ifid_hold,
  output logic                 idex_bubble,
  output logic                 ifid_flush,
  output logic                 pc_redirect
);
  localparam logic [REG_IDX_W-1:0] ZERO_IDX = '0;

  logic src1_live, src2_live;
  logic ex_dep, mem_dep, resolves_here;
  logic stall, redirect_req;

  assign src1_live = id_rs1_rd && (id_rs1 != ZERO_IDX);
  assign src2_live = id_rs2_rd && (id_rs2 != ZERO_IDX);

  assign ex_dep  = ex_wen  && ((src1_live && ex_rd  == id_rs1) || (src2_live && ex_rd  == id_rs2));
  assign mem_dep = mem_wen && ((src1_live && mem_rd == id_rs1) || (src2_live && mem_rd == id_rs2));

  assign resolves_here = id_is_br || id_is_jalr;

  assign stall = (ex_dep && (ex_load || resolves_here)) || (mem_dep && resolves_here);

  assign redirect_req = (id_is_br && id_br_taken) || id_is_jalr || id_is_jal;

  assign pc_hold     = stall;
  assign ifid_hold   = stall;
  assign idex_bubble = stall;
  assign ifid_flush  = redirect_req && !stall;
  assign pc_redirect = redirect_req && !stall;
endmodule

// File: rtl/hazard_ctl_chk.sv
module hazard_ctl_chk #(
  parameter int REG_IDX_W = 5
) (
  input logic [REG_IDX_W-1:0] id_rs1,
  input logic [REG_IDX_W-1:0] id_rs2,
  input logic                 id_rs1_rd,
  input logic                 id_rs2_rd,
  input logic                 id_is_br,
  input logic                 id_is_jalr,
  input logic                 id_is_jal,
  input logic                 id_br_taken,
  input logic [REG_IDX_W-1:0] ex_rd,
  input logic                 ex_wen,
  input logic                 ex_load,
  input logic [REG_IDX_W-1:0] mem_rd,
  input logic                 mem_wen,
  input logic                 pc_hold,
  input logic                 ifid_hold,
  input logic                 idex_bubble,
  input logic                 ifid_flush,
  input logic                 pc_redirect
);
  always_comb begin
    if (!id_is_br && !id_is_jalr && !id_is_jal && !ex_load)
      p_idle_quiet_r1: assert (!pc_hold && !ifid_flush && !pc_redirect);
    if (pc_hold)
      p_stall_agree_r2: assert (ifid_hold && idex_bubble);
    if (ex_load && ex_wen && id_rs1_rd && id_rs1 != '0 && ex_rd == id_rs1)
      p_load_use_r2: assert (pc_hold);
    if ((id_is_br || id_is_jalr) && ex_wen && id_rs2_rd && id_rs2 != '0 && ex_rd == id_rs2)
      p_ctl_after_ex_r4: assert (pc_hold);
    if ((id_is_br || id_is_jalr) && mem_wen && id_rs1_rd && id_rs1 != '0 && mem_rd == id_rs1)
      p_ctl_after_mem_r5: assert (pc_hold);
    if (id_rs1 == '0 && id_rs2 == '0)
      p_zero_src_r6: assert (!pc_hold);
    if (id_is_br && !id_br_taken && !id_is_jal && !id_is_jalr)
      p_not_taken_r7: assert (!ifid_flush && !pc_redirect);
    if (pc_hold)
      p_stall_wins_r8: assert (!ifid_flush && !pc_redirect);
  end
endmodule

bind hazard_ctl hazard_ctl_chk #(.REG_IDX_W(REG_IDX_W)) u_chk (.*);

// File: tb/hazard_ctl_bench.sv
`timescale 1ns/1ps
module hazard_ctl_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [4:0] id_rs1, id_rs2, ex_rd, mem_rd;
  logic id_rs1_rd, id_rs2_rd, id_is_br, id_is_jalr, id_is_jal, id_br_taken;
  logic ex_wen, ex_load, mem_wen;
  logic pc_hold, ifid_hold, idex_bubble, ifid_flush, pc_redirect;

  int n_run = 0;
  int n_fail = 0;

  localparam logic [4:0] NONE  = 5'b00000;
  localparam logic [4:0] STALL = 5'b11100;
  localparam logic [4:0] FLUSH = 5'b00011;

  hazard_ctl u_hazard_ctl (.*);

  task automatic clr();
    @(negedge clk);
    id_rs1 = 5'd0; id_rs2 = 5'd0; id_rs1_rd = 0; id_rs2_rd = 0;
    id_is_br = 0; id_is_jalr = 0; id_is_jal = 0; id_br_taken = 0;
    ex_rd = 5'd0; ex_wen = 0; ex_load = 0; mem_rd = 5'd0; mem_wen = 0;
  endtask

  task automatic chk(input logic [4:0] exp, input string tag);
    logic [4:0] got;
    #3;
    got = {pc_hold, ifid_hold, idex_bubble, ifid_flush, pc_redirect};
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic t_idle();
    clr(); chk(NONE, "R1 all-zero inputs");
    clr(); id_rs1 = 5'd3; id_rs1_rd = 1; ex_rd = 5'd3; ex_wen = 1; chk(NONE, "R1 ALU after ALU");
  endtask

  task automatic t_load_use();
    clr(); id_rs1 = 5'd15; id_rs1_rd = 1; ex_rd = 5'd15; ex_wen = 1; ex_load = 1;
    chk(STALL, "R2 load-use rs1");
    clr(); id_rs1 = 5'd4; id_rs2 = 5'd9; id_rs1_rd = 1; id_rs2_rd = 1;
    ex_rd = 5'd9; ex_wen = 1; ex_load = 1; chk(STALL, "R2 load-use rs2");
    clr(); id_rs1 = 5'd4; id_rs1_rd = 1; ex_rd = 5'd5; ex_wen = 1; ex_load = 1;
    chk(NONE, "R2 load to other register");
  endtask

  task automatic t_forwardable();
    clr(); id_rs2 = 5'd7; id_rs2_rd = 1; ex_rd = 5'd7; ex_wen = 1; chk(NONE, "R3 ALU producer in EX");
    clr(); id_rs1 = 5'd7; id_rs1_rd = 1; mem_rd = 5'd7; mem_wen = 1; chk(NONE, "R3 producer in MEM");
  endtask

  task automatic t_ctl_deps();
    clr(); id_is_br = 1; id_br_taken = 1; id_rs1 = 5'd14; id_rs2 = 5'd15; id_rs1_rd = 1; id_rs2_rd = 1;
    ex_rd = 5'd15; ex_wen = 1; chk(STALL, "R4 branch after ALU");
    clr(); id_is_br = 1; id_rs1 = 5'd14; id_rs1_rd = 1; id_rs2_rd = 1; id_rs2 = 5'd2;
    ex_rd = 5'd14; ex_wen = 1; ex_load = 1; chk(STALL, "R4 branch after load");
    clr(); id_is_jalr = 1; id_rs1 = 5'd1; id_rs1_rd = 1; ex_rd = 5'd1; ex_wen = 1;
    chk(STALL, "R4 jalr base in EX");
    clr(); id_is_br = 1; id_rs1 = 5'd8; id_rs1_rd = 1; id_rs2_rd = 1; id_rs2 = 5'd6;
    mem_rd = 5'd6; mem_wen = 1; chk(STALL, "R5 branch after MEM producer");
    clr(); id_is_jalr = 1; id_rs1 = 5'd1; id_rs1_rd = 1; mem_rd = 5'd1; mem_wen = 1;
    chk(STALL, "R5 jalr base in MEM");
  endtask

  task automatic t_masks();
    clr(); id_is_br = 1; id_rs1_rd = 1; id_rs2_rd = 1; ex_rd = 5'd0; ex_wen = 1; ex_load = 1;
    mem_wen = 1; chk(NONE, "R6 x0 source");
    clr(); id_rs2 = 5'd5; id_rs2_rd = 0; id_rs1 = 5'd2; id_rs1_rd = 1;
    ex_rd = 5'd5; ex_wen = 1; ex_load = 1; chk(NONE, "R6 unread rs2");
    clr(); id_is_br = 1; id_rs1 = 5'd5; id_rs1_rd = 1; ex_rd = 5'd5; ex_wen = 0; ex_load = 1;
    mem_rd = 5'd5; mem_wen = 0; chk(NONE, "R6 write enables low");
  endtask

  task automatic t_flush();
    clr(); id_is_br = 1; id_br_taken = 1; id_rs1 = 5'd3; id_rs1_rd = 1; chk(FLUSH, "R7 taken branch");
    clr(); id_is_br = 1; id_br_taken = 0; id_rs1 = 5'd3; id_rs1_rd = 1; chk(NONE, "R7 not-taken branch");
    clr(); id_is_jal = 1; ex_rd = 5'd1; ex_wen = 1; ex_load = 1; chk(FLUSH, "R7 direct jump");
    clr(); id_is_jalr = 1; id_rs1 = 5'd10; id_rs1_rd = 1; ex_rd = 5'd11; ex_wen = 1;
    chk(FLUSH, "R7 jalr no dependency");
  endtask

  task automatic t_priority();
    clr(); id_is_br = 1; id_br_taken = 1; id_rs1 = 5'd12; id_rs1_rd = 1; ex_rd = 5'd12; ex_wen = 1;
    chk(STALL, "R8 taken branch stalled");
    clr(); id_is_jalr = 1; id_rs1 = 5'd20; id_rs1_rd = 1; mem_rd = 5'd20; mem_wen = 1;
    chk(STALL, "R8 jalr stalled");
  endtask

  initial begin
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    id_rs1 = 5'd0; id_rs2 = 5'd0; id_rs1_rd = 0; id_rs2_rd = 0;
    id_is_br = 0; id_is_jalr = 0; id_is_jal = 0; id_br_taken = 0;
    ex_rd = 5'd0; ex_wen = 0; ex_load = 0; mem_rd = 5'd0; mem_wen = 0;
    t_idle();
    t_load_use();
    t_forwardable();
    t_ctl_deps();
    t_masks();
    t_flush();
    t_priority();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule